// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a write-only configuration port driven by three wires: a load strobe, a shift clock and a serial data line. While the load strobe is low, each rising edge of the shift clock moves one data bit into a 16-bit shift register, least significant bit first. When the load strobe rises, the word currently in the shift register is decoded into a small staging register file in the strobe's own timing domain.

The staged values are then handed to the conversion-clock domain through a toggle handshake. The conversion-clock registers drive four outputs: a standby bit, a 10-bit gain code, a 4-bit black-clamp level code and a 3-bit strobe-polarity field. A word whose test flag is set, or whose address is reserved, is shifted in normally but changes nothing. An asynchronous active-low reset returns every register to its default value.

Top module: `sci_cfg_port`

## Requirements
- R1: Bits are shifted only on a rising shift-clock edge while the load strobe is low; shift-clock edges while the strobe is high leave the shift register unchanged.
- R2: Serial bits arrive least significant first, so the first bit of a 16-bit word lands in bit 0. The word is taken into the staging registers on the rising edge of the load strobe.
- R3: If more than 16 bits are shifted before a load edge, only the last 16 take effect.
- R4: Word layout: bit 15 is the test flag, bits 14..12 are the address and bits 11..0 are data. At address 0, data bit 0 sets the standby output (1 = standby, 0 = active).
- R5: At address 1, data bits 9..0 set the gain code.
- R6: At address 2, data bits 3..0 set the clamp level code. The upper data bits are ignored.
- R7: At address 3, data bits 2..0 set the polarity field.
- R8: A word with bit 15 set, or with an address from 4 to 7, leaves every output unchanged.
- R9: An asynchronous active-low reset forces standby 0, gain 128, clamp 8 and polarity 0.
- R10: A written value appears on the outputs at the fifth conversion-clock rising edge after the load edge, and never later than the sixth. Between updates, the outputs hold their values.
- R11: Writes are still accepted and delivered while the standby output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_load | input | 1 | Load strobe: low enables shifting, rising edge takes the word |
| ser_data | input | 1 | Serial data, least significant bit first |
| conv_clk | input | 1 | Conversion clock for the output registers |
| cfg_standby | output | 1 | Standby control bit |
| cfg_gain | output | 10 | Gain code |
| cfg_clamp | output | 4 | Black-clamp level code |
| cfg_polarity | output | 3 | Strobe polarity field |

## Verification
The hardest case to reach from the ports is one where shift-clock pulses arrive while the strobe is high and the next word is shorter than 16 bits. Only then do stale bits from the earlier word show whether shifting was correctly blocked. The bench first writes a full word, then pulses the shift clock with the strobe high and the data held at 1, and then shifts in only eight new bits. The loaded word is made of the new byte and the upper byte of the earlier word, and it gives a different gain code if any of the unwanted ones had entered. Exact update latency is checked by running the serial edges on a phase fixed against the conversion clock, and by comparing a bench-side model on every cycle.

// File: rtl/sci_pkg.sv
`timescale 1ns/1ps
// sci_pkg: shared sizes, field positions, register addresses and the
// configuration record for the serial control register interface.
package sci_pkg;
    parameter int WORD_W      = 16;
    parameter int ADDR_W      = 3;
    parameter int DATA_W      = 12;
    parameter int GAIN_W      = 10;
    parameter int CLAMP_W     = 4;
    parameter int POL_W       = 3;
    parameter int SYNC_STAGES = 2;
    parameter int EXTRA_DELAY = 2;

    localparam int TEST_BIT = WORD_W - 1;
    localparam int ADDR_LSB = DATA_W;
    localparam int ADDR_MSB = DATA_W + ADDR_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MODE  = 3'd0,
        ADDR_GAIN  = 3'd1,
        ADDR_CLAMP = 3'd2,
        ADDR_POL   = 3'd3
    } addr_e;

    typedef struct packed {
        logic               standby;
        logic [GAIN_W-1:0]  gain;
        logic [CLAMP_W-1:0] clamp;
        logic [POL_W-1:0]   pol;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{
        standby: 1'b0,
        gain:    10'd128,
        clamp:   4'b1000,
        pol:     3'b000
    };
endpackage

// File: rtl/sci_shifter.sv
`timescale 1ns/1ps
// sci_shifter: serial-in shift register. It captures one bit per rising
// ser_clk edge while ser_load is low, entering at the top so that the first
// bit of a word ends in bit 0. Older bits fall off the bottom, so the last
// WIDTH bits are always kept.
// Assumes ser_data is stable around the rising ser_clk edge.
module sci_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             ser_clk,
    input  logic             rst_n,
    input  logic             ser_load,
    input  logic             ser_data,
    output logic [WIDTH-1:0] word_o
);
    logic [WIDTH-1:0] shift_q;

    // Shift one bit in from the top while the load strobe is low.
    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (!ser_load) begin
            shift_q <= {ser_data, shift_q[WIDTH-1:1]};
        end
    end

    assign word_o = shift_q;
endmodule

// File: rtl/sci_decoder.sv
`timescale 1ns/1ps
// sci_decoder: on each rising edge of the load strobe, decodes the shifted
// word into the staging register file and flips a request toggle for the
// conversion-clock domain. Test-flag words and reserved addresses keep the
// staged values as they were. The toggle flips on every load edge, so a
// re-delivery of unchanged values is harmless.
// Assumes load edges are spaced at least eight conversion cycles apart.
module sci_decoder
    import sci_pkg::*;
(
    input  logic              ser_load,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output cfg_t              stage_o,
    output logic              req_tgl_o
);
    cfg_t               stage_q;
    cfg_t               stage_d;
    logic               req_q;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
    logic               unused_data_bits;

    assign addr = word_i[ADDR_MSB:ADDR_LSB];
    assign data = word_i[DATA_W-1:0];
    assign unused_data_bits = ^data[DATA_W-1:GAIN_W];

    // Select which staged field the incoming word replaces.
    always_comb begin
        stage_d = stage_q;
        if (!word_i[TEST_BIT]) begin
            case (addr)
                ADDR_MODE:  stage_d.standby = data[0];
                ADDR_GAIN:  stage_d.gain    = data[GAIN_W-1:0];
                ADDR_CLAMP: stage_d.clamp   = data[CLAMP_W-1:0];
                ADDR_POL:   stage_d.pol     = data[POL_W-1:0];
                default:    stage_d = stage_q;
            endcase
        end
    end

    // Take the decoded word and raise a crossing request on the load edge.
    always_ff @(posedge ser_load or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= CFG_DEFAULT;
            req_q   <= 1'b0;
        end else begin
            stage_q <= stage_d;
            req_q   <= ~req_q;
        end
    end

    assign stage_o   = stage_q;
    assign req_tgl_o = req_q;
endmodule

// File: rtl/sci_xfer.sv
`timescale 1ns/1ps
// sci_xfer: brings the staged configuration into the conversion-clock domain.
// The request toggle passes through SYNC_STAGES flops plus one reference flop.
// The toggle change becomes a one-cycle pulse, which is delayed EXTRA_DELAY
// cycles and then loads the output register. With the defaults the outputs
// change at the fifth conversion edge after the load edge, or at the sixth if
// the toggle misses the first edge.
// Assumes the staged values are stable from the toggle until the load pulse.
module sci_xfer
    import sci_pkg::*;
#(
    parameter int NSYNC = SYNC_STAGES,
    parameter int NDLY  = EXTRA_DELAY
) (
    input  logic conv_clk,
    input  logic rst_n,
    input  logic req_tgl_i,
    input  cfg_t stage_i,
    output logic load_en_o,
    output cfg_t cfg_o
);
    localparam int LATENCY = NSYNC + 1 + NDLY;

    logic [NSYNC:0] sync_q;
    logic           change;
    cfg_t           cfg_q;

    // Resynchronise the request toggle and keep one extra reference stage.
    always_ff @(posedge conv_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[NSYNC-1:0], req_tgl_i};
        end
    end

    assign change = sync_q[NSYNC-1] ^ sync_q[NSYNC];

    generate
        if (NDLY == 0) begin : g_nodly
            assign load_en_o = change;
        end else if (NDLY == 1) begin : g_dly1
            logic dly_q;
            // Hold the change pulse for a single cycle.
            always_ff @(posedge conv_clk or negedge rst_n) begin
                if (!rst_n) dly_q <= 1'b0;
                else        dly_q <= change;
            end
            assign load_en_o = dly_q;
        end else begin : g_dlyn
            logic [NDLY-1:0] dly_q;
            // Move the change pulse along a fixed-length delay line.
            always_ff @(posedge conv_clk or negedge rst_n) begin
                if (!rst_n) dly_q <= '0;
                else        dly_q <= {dly_q[NDLY-2:0], change};
            end
            assign load_en_o = dly_q[NDLY-1];
        end
    endgenerate

    // Load the staged values into the output registers on the delayed pulse.
    always_ff @(posedge conv_clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_DEFAULT;
        end else if (load_en_o) begin
            cfg_q <= stage_i;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/sci_cfg_port.sv
`timescale 1ns/1ps
// sci_cfg_port: top of the serial control register interface. It joins the
// shifter (serial clock), the decoder (load strobe edge) and the domain
// crossing (conversion clock), and splits the final record into output ports.
// Assumes rst_n is asserted long enough to cover at least one edge of each clock.
module sci_cfg_port
    import sci_pkg::*;
(
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_load,
    input  logic               ser_data,
    input  logic               conv_clk,
    output logic               cfg_standby,
    output logic [GAIN_W-1:0]  cfg_gain,
    output logic [CLAMP_W-1:0] cfg_clamp,
    output logic [POL_W-1:0]   cfg_polarity
);
    logic [WORD_W-1:0] shift_word;
    cfg_t              stage_cfg;
    logic              req_tgl;
    logic              load_en;
    cfg_t              cfg_q;

    sci_shifter #(.WIDTH(WORD_W)) u_shift (
        .ser_clk  (ser_clk),
        .rst_n    (rst_n),
        .ser_load (ser_load),
        .ser_data (ser_data),
        .word_o   (shift_word)
    );

    sci_decoder u_dec (
        .ser_load  (ser_load),
        .rst_n     (rst_n),
        .word_i    (shift_word),
        .stage_o   (stage_cfg),
        .req_tgl_o (req_tgl)
    );

    sci_xfer #(.NSYNC(SYNC_STAGES), .NDLY(EXTRA_DELAY)) u_xfer (
        .conv_clk  (conv_clk),
        .rst_n     (rst_n),
        .req_tgl_i (req_tgl),
        .stage_i   (stage_cfg),
        .load_en_o (load_en),
        .cfg_o     (cfg_q)
    );

    assign cfg_standby  = cfg_q.standby;
    assign cfg_gain     = cfg_q.gain;
    assign cfg_clamp    = cfg_q.clamp;
    assign cfg_polarity = cfg_q.pol;
endmodule

// File: rtl/sci_cfg_port_chk.sv
`timescale 1ns/1ps
// sci_cfg_port_chk: temporal checks on the serial port and the domain
// crossing, bound into every sci_cfg_port instance.
module sci_cfg_port_chk
    import sci_pkg::*;
(
    input logic              rst_n,
    input logic              ser_clk,
    input logic              ser_load,
    input logic              conv_clk,
    input logic [WORD_W-1:0] shift_word,
    input logic              load_en,
    input cfg_t              stage_cfg,
    input cfg_t              cfg_q
);
    // R1: a shift-clock edge with the strobe high must not move the register.
    assert_no_shift_high_R1: assert property (@(posedge ser_clk) disable iff (!rst_n)
        ser_load |=> $stable(shift_word));

    // R10: outputs only change on the cycle after a load pulse.
    assert_hold_R10: assert property (@(posedge conv_clk) disable iff (!rst_n)
        !load_en |=> $stable(cfg_q));

    // R10: a load pulse delivers the staged record.
    assert_capture_R10: assert property (@(posedge conv_clk) disable iff (!rst_n)
        load_en |=> (cfg_q == $past(stage_cfg)));

    // R10: each load edge gives one single-cycle pulse.
    assert_single_pulse_R10: assert property (@(posedge conv_clk) disable iff (!rst_n)
        load_en |=> !load_en);
endmodule

bind sci_cfg_port sci_cfg_port_chk u_chk (
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .ser_load   (ser_load),
    .conv_clk   (conv_clk),
    .shift_word (shift_word),
    .load_en    (load_en),
    .stage_cfg  (stage_cfg),
    .cfg_q      (cfg_q)
);

// File: tb/sci_cfg_port_bench.sv
`timescale 1ns/1ps
module sci_cfg_port_bench;
    import sci_pkg::*;

    localparam int LAT = 5;

    logic       rst_n;
    logic       ser_clk;
    logic       ser_load;
    logic       ser_data;
    logic       conv_clk;
    logic       cfg_standby;
    logic [9:0] cfg_gain;
    logic [3:0] cfg_clamp;
    logic [2:0] cfg_polarity;

    int checks   = 0;
    int failures = 0;
    int ncyc     = 0;
    bit done     = 0;

    // Behavioural model state
    bit   bitq[$];
    cfg_t m_stage;
    cfg_t m_out;
    cfg_t pend_val[$];
    int   pend_due[$];

    sci_cfg_port u_sci_cfg_port (
        .rst_n        (rst_n),
        .ser_clk      (ser_clk),
        .ser_load     (ser_load),
        .ser_data     (ser_data),
        .conv_clk     (conv_clk),
        .cfg_standby  (cfg_standby),
        .cfg_gain     (cfg_gain),
        .cfg_clamp    (cfg_clamp),
        .cfg_polarity (cfg_polarity)
    );

    initial conv_clk = 0;
    always #10 conv_clk = ~conv_clk;

    always @(posedge conv_clk) ncyc++;

    function automatic cfg_t model_apply(cfg_t cur, logic [15:0] w);
        cfg_t r = cur;
        if (w[15]) return r;
        case (w[14:12])
            3'd0: r.standby = w[0];
            3'd1: r.gain    = w[9:0];
            3'd2: r.clamp   = w[3:0];
            3'd3: r.pol     = w[2:0];
            default: ;
        endcase
        return r;
    endfunction

    task automatic model_reset();
        bitq.delete();
        for (int i = 0; i < 16; i++) bitq.push_back(1'b0);
        m_stage = CFG_DEFAULT;
        m_out   = CFG_DEFAULT;
        pend_val.delete();
        pend_due.delete();
    endtask

    task automatic compare(string tag, cfg_t exp);
        checks++;
        if (cfg_standby !== exp.standby || cfg_gain !== exp.gain ||
            cfg_clamp !== exp.clamp || cfg_polarity !== exp.pol) begin
            failures++;
            $display("FAIL %s t=%0t actual sb=%0b gain=%h clamp=%h pol=%h expected sb=%0b gain=%h clamp=%h pol=%h",
                     tag, $time, cfg_standby, cfg_gain, cfg_clamp, cfg_polarity,
                     exp.standby, exp.gain, exp.clamp, exp.pol);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R10 timing)
    always @(negedge conv_clk) begin
        if (!done) begin
            while (pend_due.size() > 0 && pend_due[0] <= ncyc) begin
                m_out = pend_val.pop_front();
                void'(pend_due.pop_front());
            end
            compare("R10 cycle", m_out);
        end
    end

    task automatic expect_out(string tag, logic sb, logic [9:0] g, logic [3:0] c, logic [2:0] p);
        cfg_t e;
        e.standby = sb; e.gain = g; e.clamp = c; e.pol = p;
        compare(tag, e);
    endtask

    task automatic shift_bits(logic [31:0] bits, int n);
        @(negedge conv_clk); #3;
        ser_load = 1'b0;
        for (int i = 0; i < n; i++) begin
            ser_data = bits[i];
            #25 ser_clk = 1'b1;
            bitq.push_back(bits[i]);
            if (bitq.size() > 16) void'(bitq.pop_front());
            #50 ser_clk = 1'b0;
            #25;
        end
        ser_load = 1'b1;
        begin
            logic [15:0] w;
            for (int i = 0; i < 16; i++) w[i] = bitq[i];
            m_stage = model_apply(m_stage, w);
            pend_val.push_back(m_stage);
            pend_due.push_back(ncyc + LAT);
        end
    endtask

    task automatic junk_clocks(int n);
        @(negedge conv_clk); #3;
        ser_data = 1'b1;
        for (int i = 0; i < n; i++) begin
            #25 ser_clk = 1'b1;
            #50 ser_clk = 1'b0;
            #25;
        end
        ser_data = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge conv_clk);
    endtask

    task automatic write16(logic [15:0] w);
        shift_bits({16'h0, w}, 16);
        settle();
    endtask

    initial begin
        model_reset();
        ser_clk = 0; ser_load = 1; ser_data = 0;
        rst_n = 1;
        #1 rst_n = 0;
        #52;
        @(negedge conv_clk);
        expect_out("R9 reset defaults", 1'b0, 10'd128, 4'd8, 3'd0);
        #3 rst_n = 1;
        settle();
        expect_out("R9 after release", 1'b0, 10'd128, 4'd8, 3'd0);

        // R5/R2/R10: gain write, exact latency
        shift_bits({16'h0, 16'h12A5}, 16);
        repeat (4) @(negedge conv_clk);
        expect_out("R10 not yet at edge 4", 1'b0, 10'd128, 4'd8, 3'd0);
        @(negedge conv_clk);
        expect_out("R10 updated at edge 5", 1'b0, 10'h2A5, 4'd8, 3'd0);
        settle();
        expect_out("R5 R2 gain lsb-first", 1'b0, 10'h2A5, 4'd8, 3'd0);

        write16(16'h2FF3);
        expect_out("R6 clamp upper bits ignored", 1'b0, 10'h2A5, 4'd3, 3'd0);
        write16(16'h3005);
        expect_out("R7 polarity", 1'b0, 10'h2A5, 4'd3, 3'd5);
        write16(16'h0001);
        expect_out("R4 standby set", 1'b1, 10'h2A5, 4'd3, 3'd5);
        write16(16'h13FF);
        expect_out("R11 write during standby", 1'b1, 10'h3FF, 4'd3, 3'd5);
        write16(16'h9000);
        expect_out("R8 test flag ignored", 1'b1, 10'h3FF, 4'd3, 3'd5);
        write16(16'h5FFF);
        expect_out("R8 reserved address ignored", 1'b1, 10'h3FF, 4'd3, 3'd5);

        // R3: 24 bits, only last 16 count
        shift_bits({8'h0, 16'h2006, 8'hAB}, 24);
        settle();
        expect_out("R3 long word keeps last 16", 1'b1, 10'h3FF, 4'd6, 3'd5);

        // R1: clocks with strobe high must not shift
        write16(16'h3002);
        expect_out("R7 polarity rewrite", 1'b1, 10'h3FF, 4'd6, 3'd2);
        junk_clocks(16);
        settle();
        expect_out("R1 junk clocks no effect on outputs", 1'b1, 10'h3FF, 4'd6, 3'd2);
        shift_bits({24'h0, 8'h11}, 8);
        settle();
        expect_out("R1 partial word over old bits", 1'b1, 10'h130, 4'd6, 3'd2);

        write16(16'h0000);
        expect_out("R4 standby cleared", 1'b0, 10'h130, 4'd6, 3'd2);

        // R9: asynchronous reset mid-run
        @(negedge conv_clk); #3;
        rst_n = 0;
        model_reset();
        #60;
        @(negedge conv_clk);
        expect_out("R9 mid-run reset", 1'b0, 10'd128, 4'd8, 3'd0);
        #3 rst_n = 1;
        settle();
        write16(16'h2001);
        expect_out("R6 write after reset", 1'b0, 10'd128, 4'd1, 3'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule